// File: doc/BRIEF.md
# Streaming Cell Orientation Histogram Builder

This block sits after a gradient stage that delivers, for every pixel of a frame in raster order, an 8-bit gradient magnitude and a 4-bit orientation bin index. It divides the frame into square cells of `CELL` x `CELL` pixels. For each complete cell it produces one histogram of `NBIN` sums. Sum `b` is the total magnitude of the cell's pixels whose bin index equals `b`.

Pixels arrive one per accepted cycle. A shift register collects the pixels of the current row of each cell. When a cell row segment ends on a row that does not close the cell, the packed segment goes to an on-chip RAM sized for one band of cells across the frame width. While the closing row of a cell streams in, the earlier rows of that cell are read back from the RAM, one per pixel, into a bank of `CELL` row registers. On the closing pixel the bank holds the whole cell. A one-hot decoder per pixel and one adder tree per bin then form the histogram in parallel. The result comes out with a single-cycle valid strobe and the cell's column and row indices. There is no backpressure, so the consumer must take one histogram per `CELL` accepted pixels.

Parameters set the frame width `FRAME_W`, the cell edge `CELL` (3 or more, default 9), the bin count `NBIN` (at most 16) and the width `ROWC_W` of the cell row index.

Top module: `cell_hist_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `hist_valid` is low and every sum in `hist_sums` is zero.
- R2: A pixel closes a cell when its 1-based row within the frame and its 1-based column are both multiples of `CELL`. `hist_valid` is high for exactly one cycle, two rising edges after the edge that accepts that closing pixel.
- R3: Bin `b` of the emitted histogram occupies `hist_sums[b*SUM_W +: SUM_W]`. It equals the sum of `pix_mag` over the `CELL*CELL` pixels of that cell whose `pix_bin` equals `b`.
- R4: A pixel whose `pix_bin` is `NBIN` or larger adds nothing to any bin.
- R5: `hist_cx` carries the 0-based cell column and `hist_cy` the 0-based cell row (modulo 2^`ROWC_W`) of the emitted cell.
- R6: No histogram is produced for the partial cells at the right edge (columns beyond `(FRAME_W/CELL)*CELL`) or for bottom rows that do not complete a cell band before the next frame start. `hist_cx` is always below `FRAME_W/CELL`.
- R7: A pixel accepted with `pix_sof` high is taken as row 1, column 1 of a new frame. Any partly streamed frame is abandoned.
- R8: Cycles with `pix_valid` low leave all position and cell state unchanged, so idle gaps anywhere in the stream do not alter the results.
- R9: Each sum is `SUM_W` bits wide and holds `CELL*CELL*255` without overflow.
- R10: `hist_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_sof | input | 1 | The presented pixel is the first of a frame |
| pix_mag | input | 8 | Gradient magnitude of the pixel |
| pix_bin | input | 4 | Orientation bin index of the pixel |
| hist_valid | output | 1 | One-cycle strobe: a cell histogram is on `hist_sums` |
| hist_cx | output | max(1,clog2(FRAME_W/CELL)) | Column index of the cell |
| hist_cy | output | ROWC_W | Row index of the cell |
| hist_sums | output | NBIN*SUM_W | Packed bin sums, bin 0 in the low bits |

## Verification
Each histogram is due in the cycle after the second rising edge that follows acceptance of its closing pixel. This holds whatever idle gaps come before the closing pixel. The bench records the cycle in which it drives every closing pixel and queues the expected cell with a due cycle two edges later. It samples outputs on the falling edge and matches each strobe to the head of that queue. A strobe in any other cycle, an expected strobe that never comes, or two strobes in a row each count as a failure. Expected sums are recomputed in the bench from the same pixel generator that fed the stimulus.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
package chg_pkg;
  localparam int MAG_W = 8;
  localparam int BIN_W = 4;
  localparam int PIX_W = MAG_W + BIN_W;

  typedef struct packed {
    logic [MAG_W-1:0] mag;
    logic [BIN_W-1:0] bin;
  } pix_t;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/chg_raster_ctr.sv
`timescale 1ns/1ps
// Tracks the raster position of the presented pixel: pixel-in-cell, row-in-cell,
// cell column and cell row. Outputs describe the pixel on the input this cycle.
module chg_raster_ctr #(
  parameter int FRAME_W = 64,
  parameter int CELL    = 9,
  parameter int ROWC_W  = 8,
  parameter int COL_W   = 6,
  parameter int K_W     = 4,
  parameter int CXC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_sof,
  output logic [K_W-1:0]    pos_k,
  output logic [K_W-1:0]    pos_rr,
  output logic [CXC_W-1:0]  pos_cx,
  output logic [ROWC_W-1:0] pos_cy
);
  logic [COL_W-1:0]  col_q, col_d, pos_col;
  logic [K_W-1:0]    k_q, k_d, rr_q, rr_d;
  logic [CXC_W-1:0]  cx_q, cx_d;
  logic [ROWC_W-1:0] cy_q, cy_d;

  // next-state
  always_comb begin
    pos_col = pix_sof ? '0 : col_q;
    pos_k   = pix_sof ? '0 : k_q;
    pos_rr  = pix_sof ? '0 : rr_q;
    pos_cx  = pix_sof ? '0 : cx_q;
    pos_cy  = pix_sof ? '0 : cy_q;
    col_d = col_q;
    k_d   = k_q;
    rr_d  = rr_q;
    cx_d  = cx_q;
    cy_d  = cy_q;
    if (pix_valid) begin
      if (pos_col == COL_W'(FRAME_W - 1)) begin
        col_d = '0;
        k_d   = '0;
        cx_d  = '0;
        if (pos_rr == K_W'(CELL - 1)) begin
          rr_d = '0;
          cy_d = pos_cy + 1'b1;
        end else begin
          rr_d = pos_rr + 1'b1;
          cy_d = pos_cy;
        end
      end else begin
        col_d = pos_col + 1'b1;
        rr_d  = pos_rr;
        cy_d  = pos_cy;
        if (pos_k == K_W'(CELL - 1)) begin
          k_d  = '0;
          cx_d = pos_cx + 1'b1;
        end else begin
          k_d  = pos_k + 1'b1;
          cx_d = pos_cx;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      k_q   <= '0;
      rr_q  <= '0;
      cx_q  <= '0;
      cy_q  <= '0;
    end else if (pix_valid) begin
      col_q <= col_d;
      k_q   <= k_d;
      rr_q  <= rr_d;
      cx_q  <= cx_d;
      cy_q  <= cy_d;
    end
  end
endmodule

// File: rtl/chg_row_store.sv
`timescale 1ns/1ps
// Simple dual-port storage for packed cell row segments, registered read.
module chg_row_store #(
  parameter int DEPTH = 56,
  parameter int WIDTH = 108,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chg_bin_accum.sv
`timescale 1ns/1ps
// Parallel histogram: one-hot decode per pixel, one adder tree per bin.
module chg_bin_accum
  import chg_pkg::*;
#(
  parameter int CELL  = 9,
  parameter int NBIN  = 9,
  parameter int SUM_W = 15
) (
  input  logic [CELL*CELL*PIX_W-1:0] cell_px,
  output logic [NBIN*SUM_W-1:0]      sums
);
  localparam int NPIX = CELL * CELL;

  logic [NBIN-1:0]  sel [NPIX];
  logic [MAG_W-1:0] mag [NPIX];

  for (genvar p = 0; p < NPIX; p++) begin : g_dec
    pix_t px;
    assign px     = cell_px[p*PIX_W +: PIX_W];
    assign mag[p] = px.mag;
    // an index at or above NBIN shifts the single bit out: no bin selected
    assign sel[p] = NBIN'(1) << px.bin;
  end

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    logic [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int p = 0; p < NPIX; p++) begin
        if (sel[p][b]) acc = acc + SUM_W'(mag[p]);
      end
    end
    assign sums[b*SUM_W +: SUM_W] = acc;
  end
endmodule

// File: rtl/cell_hist_gen.sv
`timescale 1ns/1ps
module cell_hist_gen
  import chg_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int CELL    = 9,
  parameter int NBIN    = 9,
  parameter int ROWC_W  = 8,
  localparam int NCX    = FRAME_W / CELL,
  localparam int CX_W   = bits_for(NCX),
  localparam int SUM_W  = $clog2(CELL * CELL * ((1 << MAG_W) - 1) + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_valid,
  input  logic                  pix_sof,
  input  logic [MAG_W-1:0]      pix_mag,
  input  logic [BIN_W-1:0]      pix_bin,
  output logic                  hist_valid,
  output logic [CX_W-1:0]       hist_cx,
  output logic [ROWC_W-1:0]     hist_cy,
  output logic [NBIN*SUM_W-1:0] hist_sums
);
  localparam int COL_W  = bits_for(FRAME_W);
  localparam int K_W    = bits_for(CELL);
  localparam int CXC_W  = bits_for(NCX + 1);
  localparam int DEPTH  = NCX * (CELL - 1);
  localparam int AW     = bits_for(DEPTH);
  localparam int ROW_W  = CELL * PIX_W;
  localparam int COLL_W = (CELL - 1) * PIX_W;

  logic [K_W-1:0]    pos_k, pos_rr;
  logic [CXC_W-1:0]  pos_cx;
  logic [ROWC_W-1:0] pos_cy;

  chg_raster_ctr #(
    .FRAME_W(FRAME_W), .CELL(CELL), .ROWC_W(ROWC_W),
    .COL_W(COL_W), .K_W(K_W), .CXC_W(CXC_W)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pos_k(pos_k), .pos_rr(pos_rr), .pos_cx(pos_cx), .pos_cy(pos_cy)
  );

  pix_t cur_pix;
  assign cur_pix = '{mag: pix_mag, bin: pix_bin};

  logic in_cell, seg_end, last_row;
  logic cell_close, ram_we, ram_re;
  assign in_cell    = pos_cx < CXC_W'(NCX);
  assign seg_end    = pos_k == K_W'(CELL - 1);
  assign last_row   = pos_rr == K_W'(CELL - 1);
  assign cell_close = pix_valid && in_cell && seg_end && last_row;
  assign ram_we     = pix_valid && in_cell && seg_end && !last_row;
  assign ram_re     = pix_valid && in_cell && !seg_end && last_row;

  // row segment collector (shift register of the previous CELL-1 pixels)
  logic [COLL_W-1:0] coll_q, coll_d;
  logic [ROW_W-1:0]  row_now;
  assign row_now = {coll_q, cur_pix};
  always_comb coll_d = pix_valid ? COLL_W'(row_now) : coll_q;

  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [ROW_W-1:0] ram_rdata;
  assign ram_waddr = AW'(int'(pos_cx) * (CELL - 1) + int'(pos_rr));
  assign ram_raddr = AW'(int'(pos_cx) * (CELL - 1) + int'(pos_k));

  chg_row_store #(.DEPTH(DEPTH), .WIDTH(ROW_W), .AW(AW)) u_store (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(row_now),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  // row bank: earlier rows arrive from storage, closing row from the collector
  logic               rd_load_q;
  logic [K_W-1:0]     rd_row_q;
  logic [ROW_W-1:0]   bank_q [CELL];
  logic [ROW_W-1:0]   bank_d [CELL];
  logic               fire_q;
  logic [CX_W-1:0]    cx_hold_q;
  logic [ROWC_W-1:0]  cy_hold_q;

  always_comb begin
    for (int r = 0; r < CELL; r++) bank_d[r] = bank_q[r];
    if (rd_load_q)  bank_d[rd_row_q] = ram_rdata;
    if (cell_close) bank_d[CELL-1]   = row_now;
  end

  logic [CELL*ROW_W-1:0] bank_flat;
  for (genvar r = 0; r < CELL; r++) begin : g_flat
    assign bank_flat[r*ROW_W +: ROW_W] = bank_q[r];
  end

  logic [NBIN*SUM_W-1:0] sums_now;
  chg_bin_accum #(.CELL(CELL), .NBIN(NBIN), .SUM_W(SUM_W)) u_accum (
    .cell_px(bank_flat), .sums(sums_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_q    <= '0;
      rd_load_q <= 1'b0;
      rd_row_q  <= '0;
      fire_q    <= 1'b0;
      cx_hold_q <= '0;
      cy_hold_q <= '0;
      for (int r = 0; r < CELL; r++) bank_q[r] <= '0;
    end else begin
      rd_load_q <= ram_re;
      fire_q    <= cell_close;
      if (pix_valid) coll_q <= coll_d;
      if (ram_re) rd_row_q <= pos_k;
      if (cell_close) begin
        cx_hold_q <= CX_W'(pos_cx);
        cy_hold_q <= pos_cy;
      end
      for (int r = 0; r < CELL; r++) bank_q[r] <= bank_d[r];
    end
  end

  // output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_valid <= 1'b0;
      hist_cx    <= '0;
      hist_cy    <= '0;
      hist_sums  <= '0;
    end else begin
      hist_valid <= fire_q;
      if (fire_q) begin
        hist_cx   <= cx_hold_q;
        hist_cy   <= cy_hold_q;
        hist_sums <= sums_now;
      end
    end
  end
endmodule

// File: rtl/cell_hist_gen_sva.sv
`timescale 1ns/1ps
module cell_hist_gen_sva #(
  parameter int CELL  = 9,
  parameter int NBIN  = 9,
  parameter int NCX   = 7,
  parameter int CX_W  = 3,
  parameter int SUM_W = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cell_close,
  input logic                  hist_valid,
  input logic [CX_W-1:0]       hist_cx,
  input logic [NBIN*SUM_W-1:0] hist_sums
);
  int unsigned total;
  always_comb begin
    total = 0;
    for (int b = 0; b < NBIN; b++) total = total + 32'(hist_sums[b*SUM_W +: SUM_W]);
  end

  AST_CLOSE_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    cell_close |-> ##2 hist_valid);                                  // R2
  AST_OUT_HAS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    hist_valid |-> $past(cell_close, 2));                            // R2
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    hist_valid |=> !hist_valid);                                     // R10
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hist_valid |-> total <= 32'(CELL * CELL * 255));                 // R9
  AST_CX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hist_valid |-> 32'(hist_cx) < 32'(NCX));                         // R6
endmodule

bind cell_hist_gen cell_hist_gen_sva #(
  .CELL(CELL), .NBIN(NBIN), .NCX(NCX), .CX_W(CX_W), .SUM_W(SUM_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cell_close(cell_close),
  .hist_valid(hist_valid), .hist_cx(hist_cx), .hist_sums(hist_sums)
);

// File: tb/cell_hist_gen_tb_top.sv
`timescale 1ns/1ps
module cell_hist_gen_tb_top;
  import chg_pkg::*;

  localparam int FW  = 11;
  localparam int CL  = 3;
  localparam int NB  = 5;
  localparam int RCW = 8;
  localparam int NCX = FW / CL;
  localparam int CXW = bits_for(NCX);
  localparam int SW  = $clog2(CL * CL * 255 + 1);

  // stimulus table: mode, seed, rows, gap
  // mode 0 mixed bins (some out of range), 1 all 255 in bin 2, 2 only out-of-range bins
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{0, 1, 6, 0},
    '{0, 2, 7, 1},
    '{1, 0, 3, 0},
    '{2, 3, 3, 0},
    '{0, 4, 3, 1},
    '{0, 9, 4, 0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pix_valid, pix_sof;
  logic [MAG_W-1:0] pix_mag;
  logic [BIN_W-1:0] pix_bin;
  logic hist_valid;
  logic [CXW-1:0] hist_cx;
  logic [RCW-1:0] hist_cy;
  logic [NB*SW-1:0] hist_sums;

  always #2.5 clk = ~clk;

  cell_hist_gen #(.FRAME_W(FW), .CELL(CL), .NBIN(NB), .ROWC_W(RCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_mag(pix_mag), .pix_bin(pix_bin), .hist_valid(hist_valid),
    .hist_cx(hist_cx), .hist_cy(hist_cy), .hist_sums(hist_sums)
  );

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  bit mon_en = 1'b0;
  bit prev_v = 1'b0;
  int q_due[$], q_cx[$], q_cy[$], q_mode[$], q_seed[$], q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] pv(int mode, int seed, int r, int c);
    logic [7:0] m;
    logic [3:0] b;
    m = 8'((seed * 37 + r * 11 + c * 7 + r * c) % 256);
    b = 4'((seed + r * 3 + c * 5) % (NB + 2));
    if (mode == 1) begin m = 8'd255; b = 4'd2; end
    if (mode == 2) b = 4'(NB + (r + c) % 3);
    return {m, b};
  endfunction

  function automatic int exp_sum(int mode, int seed, int cx, int cy, int b);
    int s;
    logic [11:0] v;
    s = 0;
    for (int rr = 0; rr < CL; rr++)
      for (int cc = 0; cc < CL; cc++) begin
        v = pv(mode, seed, cy * CL + rr, cx * CL + cc);
        if (int'(v[3:0]) == b) s += int'(v[11:4]);
      end
    return s;
  endfunction

  function automatic string tag_name(int t);
    case (t)
      4: return "R4";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      while (q_due.size() > 0 && q_due[0] < cyc) begin
        check(1'b0, "R2", "histogram missing at due cycle", 0, q_due[0]);
        void'(q_due.pop_front()); void'(q_cx.pop_front()); void'(q_cy.pop_front());
        void'(q_mode.pop_front()); void'(q_seed.pop_front()); void'(q_tag.pop_front());
      end
      if (hist_valid) begin
        check(!prev_v, "R10", "strobe on consecutive cycles", 1, 0);
        if (q_due.size() == 0) begin
          check(1'b0, "R6", "unexpected histogram, cell column", int'(hist_cx), -1);
        end else begin
          check(q_due[0] == cyc, "R2", "strobe cycle", cyc, q_due[0]);
          check(int'(hist_cx) == q_cx[0] && int'(hist_cy) == q_cy[0], "R5",
                "cell index cx*256+cy", int'(hist_cx) * 256 + int'(hist_cy),
                q_cx[0] * 256 + q_cy[0]);
          for (int b = 0; b < NB; b++) begin
            int e;
            e = exp_sum(q_mode[0], q_seed[0], q_cx[0], q_cy[0], b);
            check(int'(hist_sums[b*SW +: SW]) == e, tag_name(q_tag[0]),
                  $sformatf("bin %0d sum", b), int'(hist_sums[b*SW +: SW]), e);
          end
          void'(q_due.pop_front()); void'(q_cx.pop_front()); void'(q_cy.pop_front());
          void'(q_mode.pop_front()); void'(q_seed.pop_front()); void'(q_tag.pop_front());
        end
      end
      prev_v = hist_valid;
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      pix_valid = 1'b0;
      pix_sof   = 1'b0;
    end
  endtask

  // stream rows 0..rows-1; the last row may stop after ncols_last pixels
  task automatic send_frame(int mode, int seed, int rows, int gap, int tag,
                            bit expect_out, int ncols_last);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < ((r == rows - 1) ? ncols_last : FW); c++) begin
        logic [11:0] v;
        v = pv(mode, seed, r, c);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_sof   = (r == 0 && c == 0);
        pix_mag   = v[11:4];
        pix_bin   = v[3:0];
        if (expect_out && (r + 1) % CL == 0 && (c + 1) % CL == 0 && c < NCX * CL) begin
          q_due.push_back(cyc + 2);
          q_cx.push_back(c / CL);
          q_cy.push_back(r / CL);
          q_mode.push_back(mode);
          q_seed.push_back(seed);
          q_tag.push_back(tag);
        end
        if (gap != 0 && c % 3 == 2) idle(1 + (c % 2));
      end
    end
    idle(1);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0;
    pix_valid = 1'b0;
    pix_sof = 1'b0;
    pix_mag = '0;
    pix_bin = '0;
    repeat (3) @(negedge clk);
    check(hist_valid == 1'b0 && hist_sums == '0, "R1", "outputs in reset", int'(hist_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(hist_valid == 1'b0 && hist_sums == '0, "R1", "outputs after reset", int'(hist_valid), 0);
    mon_en = 1'b1;

    // table walk: R3 mixed bins, R4 out-of-range bins, R6 edge cells, R8 gaps, R9 full scale
    for (int i = 0; i < NVEC; i++) begin
      int tg;
      tg = (VEC[i][0] == 1) ? 9 : (VEC[i][0] == 2) ? 4 : (VEC[i][3] != 0) ? 8 : 3;
      send_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], tg, 1'b1, FW);
      idle(4);
    end

    // R7: abandoned frame (two rows plus two pixels, no cell closes), then a new frame
    send_frame(1, 0, 3, 0, 7, 1'b0, 2);
    send_frame(0, 5, 6, 0, 7, 1'b1, FW);
    idle(4);

    // R1: reset in the middle of a frame, then a clean frame
    send_frame(0, 6, 2, 0, 3, 1'b0, 5);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(hist_valid == 1'b0 && hist_sums == '0, "R1", "outputs under mid-frame reset",
          int'(hist_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    send_frame(0, 7, 3, 0, 3, 1'b1, FW);
    idle(6);

    // R6: every queued cell must have been delivered
    check(q_due.size() == 0, "R6", "undelivered histograms", q_due.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule